// File: doc/BRIEF.md
# Single-Cycle Byte Accumulator Processor

This block is a small 8-bit processor that completes one instruction on every clock edge. Instructions arrive on a 16-bit program port that is addressed by the 16-bit program counter. The upper byte of each instruction word is the opcode and the lower byte is an immediate value. The core holds an accumulator, two index registers (a low index and a page register), an output latch and the program counter. It reads and writes a byte-wide data memory through a 16-bit address, and it can sample an 8-bit input port.

The opcode has three fixed fields: an operation, a mode and a bus source. The mode picks both the memory address and the destination register. The bus source picks the operand that every operation sees. Because the fields are orthogonal, a single datapath covers loads, logic, arithmetic, stores and control transfers. The core has no flags. Branch conditions are computed directly from the accumulator's sign bit and its zero state, and all arithmetic wraps modulo 256.

The program and data memories sit outside the block. Both are read combinationally within the cycle. A data write is presented as `ram_we`, `ram_addr` and `ram_wdata` and is committed by the memory at the next rising edge.

Top module: `byte_accum_core`

## Requirements
- R1: While `rst_n` is low, the program counter, accumulator, index registers and output latch are all held at 0. `rom_addr` always shows the program counter.
- R2: `rom_data[15:8]` is the opcode and `rom_data[7:0]` is the immediate byte. Opcode bits [7:5] select the operation: 0 load, 1 AND, 2 OR, 3 XOR, 4 add, 5 subtract, 6 store, 7 jump.
- R3: Opcode bits [1:0] select the bus operand: 0 the immediate, 1 the data memory byte at the effective address, 2 the accumulator, 3 `in_port`.
- R4: Operations 1 to 5 combine the accumulator with the bus operand. Sums and differences wrap modulo 256.
- R5: For operations 0 to 5, opcode bits [4:2] select the address and destination. Mode 0 uses {00,imm} and writes A. Mode 1 uses {00,X} and writes A. Mode 2 uses {Y,imm} and writes A. Mode 3 uses {Y,X} and writes A. Modes 4, 5 and 6 use {00,imm} and write X, Y and OUT respectively.
- R6: Mode 7 for operations 0 to 5 uses {Y,X}, writes OUT and increments X. X wraps from FF to 00.
- R7: A store writes the bus operand to memory. Modes 0, 4, 5 and 6 address {00,imm}, mode 1 addresses {00,X}, mode 2 addresses {Y,imm} and mode 3 addresses {Y,X}. Store mode 4 also copies A to X, and store mode 5 also copies A to Y.
- R8: Store mode 7 writes to {Y,X} and then increments X.
- R9: Jump mode 0 loads the program counter with {Y, bus operand}.
- R10: Jump mode 7 replaces only the low byte of the program counter with the bus operand. For jumps, a bus source of 1 reads memory at {00,imm}.
- R11: Jump modes 1 to 6 replace the low byte when their condition on the signed accumulator holds: 1 A>0, 2 A<0, 3 A!=0, 4 A==0, 5 A>=0, 6 A<=0. Otherwise the program counter increments.
- R12: Every instruction that is not a jump advances the program counter by one, wrapping from FFFF to 0000.
- R13: With the accumulator as the bus source, AND and OR leave the value unchanged, XOR gives 0, add gives twice A and subtract gives 0.
- R14: A store whose bus source is memory writes an unspecified byte to its address only. It leaves every register except the mode's X increment unchanged and advances the program counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rom_addr | output | 16 | Program counter to the program memory |
| rom_data | input | 16 | Instruction word: opcode high byte, immediate low byte |
| ram_addr | output | 16 | Effective data memory address |
| ram_rdata | input | 8 | Data memory read byte for `ram_addr` |
| ram_wdata | output | 8 | Data memory write byte |
| ram_we | output | 1 | Data memory write enable, committed on the next edge |
| in_port | input | 8 | External input byte |
| out_port | output | 8 | Output latch |
| acc | output | 8 | Accumulator |
| xreg | output | 8 | Low index register |
| yreg | output | 8 | Page index register |

## Verification
Every architectural register is visible at a port one edge after the instruction that writes it. A wrong accumulator also shows up in the same cycle on `ram_wdata` for any later store that uses the accumulator as its source, and it changes the branch decisions that follow. A wrong program counter shows up on `rom_addr` right after the faulty edge and stays wrong from then on. A bad address decode shows up as a wrong byte in the data memory, which the bench compares against its own model after every instruction.

// File: rtl/byte_accum_core.sv
module byte_accum_core #(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] rom_addr,
  input  logic [15:0] rom_data,
  output logic [15:0] ram_addr,
  input  logic [7:0]  ram_rdata,
  output logic [7:0]  ram_wdata,
  output logic        ram_we,
  input  logic [7:0]  in_port,
  output logic [7:0]  out_port,
  output logic [7:0]  acc,
  output logic [7:0]  xreg,
  output logic [7:0]  yreg
);

  localparam logic [2:0] OP_LD  = 3'd0;
  localparam logic [2:0] OP_AND = 3'd1;
  localparam logic [2:0] OP_OR  = 3'd2;
  localparam logic [2:0] OP_XOR = 3'd3;
  localparam logic [2:0] OP_ADD = 3'd4;
  localparam logic [2:0] OP_ST  = 3'd6;
  localparam logic [2:0] OP_JMP = 3'd7;

  logic [7:0]  a_q, x_q, y_q, o_q;
  logic [15:0] pc_q, pc_nx;
  logic [7:0]  bus, alu;
  logic        taken;

  wire [2:0] fn  = rom_data[15:13];
  wire [2:0] md  = rom_data[12:10];
  wire [1:0] src = rom_data[9:8];
  wire [7:0] imm = rom_data[7:0];

  wire is_jmp = (fn == OP_JMP);
  wire is_st  = (fn == OP_ST);
  wire a_neg  = a_q[7];
  wire a_zero = (a_q == 8'h00);

  always_comb begin
    if (is_jmp) ram_addr = {8'h00, imm};
    else begin
      case (md)
        3'd1:         ram_addr = {8'h00, x_q};
        3'd2:         ram_addr = {y_q, imm};
        3'd3, 3'd7:   ram_addr = {y_q, x_q};
        default:      ram_addr = {8'h00, imm};
      endcase
    end
  end

  always_comb begin
    case (src)
      2'd0:    bus = imm;
      2'd1:    bus = ram_rdata;
      2'd2:    bus = a_q;
      default: bus = in_port;
    endcase
  end

  always_comb begin
    case (fn)
      OP_LD:   alu = bus;
      OP_AND:  alu = a_q & bus;
      OP_OR:   alu = a_q | bus;
      OP_XOR:  alu = a_q ^ bus;
      OP_ADD:  alu = a_q + bus;
      default: alu = a_q - bus;
    endcase
  end

  always_comb begin
    case (md)
      3'd1:    taken = !a_neg && !a_zero;
      3'd2:    taken = a_neg;
      3'd3:    taken = !a_zero;
      3'd4:    taken = a_zero;
      3'd5:    taken = !a_neg;
      3'd6:    taken = a_neg || a_zero;
      default: taken = 1'b1;
    endcase
  end

  always_comb begin
    if (is_jmp && taken)
      pc_nx = (md == 3'd0) ? {y_q, bus} : {pc_q[15:8], bus};
    else
      pc_nx = pc_q + 16'd1;
  end

  assign ram_we    = is_st;
  assign ram_wdata = bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
      a_q  <= 8'h00;
      x_q  <= 8'h00;
      y_q  <= 8'h00;
      o_q  <= 8'h00;
    end else begin
      pc_q <= pc_nx;
      if (is_st) begin
        case (md)
          3'd4:    x_q <= a_q;
          3'd5:    y_q <= a_q;
          3'd7:    x_q <= x_q + 8'd1;
          default: ;
        endcase
      end else if (!is_jmp) begin
        case (md)
          3'd4:    x_q <= alu;
          3'd5:    y_q <= alu;
          3'd6:    o_q <= alu;
          3'd7: begin
            o_q <= alu;
            x_q <= x_q + 8'd1;
          end
          default: a_q <= alu;
        endcase
      end
    end
  end

  assign rom_addr = pc_q;
  assign acc      = a_q;
  assign xreg     = x_q;
  assign yreg     = y_q;
  assign out_port = o_q;

endmodule

// File: rtl/byte_accum_core_chk.sv
module byte_accum_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rom_addr,
  input logic [15:0] rom_data,
  input logic [7:0]  acc,
  input logic [7:0]  xreg,
  input logic [7:0]  yreg
);

  wire [2:0] c_fn  = rom_data[15:13];
  wire [2:0] c_md  = rom_data[12:10];
  wire [1:0] c_src = rom_data[9:8];

  a_r12_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (c_fn != 3'd7) |=> (rom_addr == $past(rom_addr) + 16'd1));

  a_r10_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (c_fn == 3'd7 && c_md != 3'd0) |=> (rom_addr[15:8] == $past(rom_addr[15:8])));

  a_r9_far_target: assert property (@(posedge clk) disable iff (!rst_n)
    (c_fn == 3'd7 && c_md == 3'd0 && c_src == 2'd0)
      |=> (rom_addr == {$past(yreg), $past(rom_data[7:0])}));

  a_r11_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (c_fn == 3'd7 && c_md == 3'd4 && c_src == 2'd0 && acc == 8'h00)
      |=> (rom_addr == {$past(rom_addr[15:8]), $past(rom_data[7:0])}));

  a_r8_store_xinc: assert property (@(posedge clk) disable iff (!rst_n)
    (c_fn == 3'd6 && c_md == 3'd7) |=> (xreg == $past(xreg) + 8'd1));

  a_r14_store_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (c_fn == 3'd6 && c_src == 2'd1 && c_md != 3'd4 && c_md != 3'd5 && c_md != 3'd7)
      |=> ($stable(acc) && $stable(xreg) && $stable(yreg)));

endmodule

bind byte_accum_core byte_accum_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
  .acc(acc), .xreg(xreg), .yreg(yreg)
);

// File: tb/sim_byte_accum_core.sv
module sim_byte_accum_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rom_addr, ram_addr;
  logic [15:0] rom_data = 16'h0000;
  logic [7:0]  ram_rdata, ram_wdata, in_port = 8'h00;
  logic [7:0]  out_port, acc, xreg, yreg;
  logic        ram_we;

  always #2 clk = ~clk;

  byte_accum_core u0 (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .in_port(in_port), .out_port(out_port),
    .acc(acc), .xreg(xreg), .yreg(yreg)
  );

  logic [7:0] mem  [4096];
  logic [7:0] mmem [4096];
  assign ram_rdata = mem[ram_addr[11:0]];
  always @(posedge clk) if (ram_we) mem[ram_addr[11:0]] <= ram_wdata;

  logic [7:0]  mA, mX, mY, mO;
  logic [15:0] mPC;
  logic        und_pend;
  logic [11:0] und_a;
  int nchk = 0, nerr = 0;

  // {requirement, opcode, immediate, in_port}
  localparam int NV = 73;
  localparam logic [31:0] VEC [NV] = '{
    {8'd5, 8'h00,8'h05,8'h00}, {8'd5, 8'h10,8'h03,8'h00}, {8'd5, 8'h14,8'h02,8'h00},
    {8'd3, 8'h01,8'h10,8'h00}, {8'd5, 8'h05,8'h00,8'h00}, {8'd5, 8'h09,8'h04,8'h00},
    {8'd5, 8'h0D,8'h00,8'h00}, {8'd3, 8'h03,8'h00,8'h81}, {8'd4, 8'h20,8'h0F,8'h00},
    {8'd4, 8'h40,8'hF0,8'h00}, {8'd4, 8'h60,8'hFF,8'h00}, {8'd4, 8'h80,8'hF5,8'h00},
    {8'd4, 8'hA0,8'h05,8'h00}, {8'd13,8'h82,8'h00,8'h00}, {8'd13,8'h22,8'h00,8'h00},
    {8'd13,8'h42,8'h00,8'h00}, {8'd13,8'h92,8'h00,8'h00}, {8'd13,8'h62,8'h00,8'h00},
    {8'd5, 8'h00,8'h7F,8'h00}, {8'd13,8'hB2,8'h00,8'h00}, {8'd5, 8'h18,8'hAA,8'h00},
    {8'd5, 8'h34,8'h0F,8'h00}, {8'd6, 8'h1E,8'h00,8'h00}, {8'd6, 8'h1D,8'h00,8'h00},
    {8'd2, 8'h37,8'h00,8'h0C}, {8'd5, 8'h14,8'h01,8'h00}, {8'd7, 8'hC2,8'h30,8'h00},
    {8'd7, 8'hC6,8'h00,8'h00}, {8'd7, 8'hC0,8'h55,8'h00}, {8'd7, 8'hCA,8'h40,8'h00},
    {8'd7, 8'hCE,8'h00,8'h00}, {8'd7, 8'hD2,8'h60,8'h00}, {8'd5, 8'h00,8'h05,8'h00},
    {8'd7, 8'hD6,8'h61,8'h00}, {8'd8, 8'hDE,8'h00,8'h00}, {8'd8, 8'hDC,8'h99,8'h00},
    {8'd3, 8'hC3,8'h62,8'h44}, {8'd7, 8'hD8,8'h64,8'h00}, {8'd14,8'hC1,8'h63,8'h00},
    {8'd14,8'hC5,8'h00,8'h00}, {8'd6, 8'h10,8'hFF,8'h00}, {8'd6, 8'h1C,8'h00,8'h00},
    {8'd8, 8'hDC,8'h12,8'h00}, {8'd4, 8'h85,8'h00,8'h00}, {8'd4, 8'hA9,8'h03,8'h00},
    {8'd11,8'h00,8'h00,8'h00}, {8'd11,8'hF0,8'h20,8'h00}, {8'd11,8'hEC,8'h30,8'h00},
    {8'd11,8'hE4,8'h31,8'h00}, {8'd11,8'hF4,8'h32,8'h00}, {8'd11,8'hF8,8'h33,8'h00},
    {8'd11,8'hE8,8'h34,8'h00}, {8'd11,8'h00,8'h80,8'h00}, {8'd11,8'hE8,8'h40,8'h00},
    {8'd11,8'hE4,8'h50,8'h00}, {8'd11,8'hF4,8'h11,8'h00}, {8'd11,8'hF8,8'h12,8'h00},
    {8'd11,8'hEC,8'h13,8'h00}, {8'd11,8'h00,8'h01,8'h00}, {8'd11,8'hE4,8'h13,8'h00},
    {8'd11,8'hF8,8'h15,8'h00}, {8'd11,8'hE8,8'h16,8'h00}, {8'd11,8'hF0,8'h18,8'h00},
    {8'd10,8'hFC,8'h77,8'h00}, {8'd10,8'hFE,8'h00,8'h00}, {8'd10,8'hFF,8'h00,8'h9A},
    {8'd10,8'hFD,8'h30,8'h00}, {8'd9, 8'hE0,8'h12,8'h00}, {8'd9, 8'hE2,8'h00,8'h00},
    {8'd9, 8'hE3,8'h00,8'hC4}, {8'd9, 8'h14,8'hFF,8'h00}, {8'd12,8'hE0,8'hFF,8'h00},
    {8'd12,8'h00,8'h42,8'h00}
  };
  // Tags: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13 R14 appear as table ids above.

  task automatic chk(input int rq, input string nm, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL R%0d %s: got %h expected %h", rq, nm, got, exp);
    end
  endtask

  task automatic ref_exec(input logic [15:0] w, input logic [7:0] inv);
    logic [2:0] f, m; logic [1:0] s; logic [7:0] d, b, r; logic [15:0] ea; logic tk;
    f = w[15:13]; m = w[12:10]; s = w[9:8]; d = w[7:0];
    if (f == 3'd7)                  ea = {8'h00, d};
    else if (m == 3'd1)             ea = {8'h00, mX};
    else if (m == 3'd2)             ea = {mY, d};
    else if (m == 3'd3 || m == 3'd7) ea = {mY, mX};
    else                            ea = {8'h00, d};
    case (s)
      2'd0: b = d;
      2'd1: b = mmem[ea[11:0]];
      2'd2: b = mA;
      default: b = inv;
    endcase
    und_pend = 1'b0;
    if (f == 3'd7) begin
      case (m)
        3'd1: tk = $signed(mA) > 0;
        3'd2: tk = $signed(mA) < 0;
        3'd3: tk = mA != 8'h00;
        3'd4: tk = mA == 8'h00;
        3'd5: tk = $signed(mA) >= 0;
        3'd6: tk = $signed(mA) <= 0;
        default: tk = 1'b1;
      endcase
      if (tk) mPC = (m == 3'd0) ? {mY, b} : {mPC[15:8], b};
      else mPC = mPC + 16'd1;
    end else begin
      mPC = mPC + 16'd1;
      if (f == 3'd6) begin
        if (s == 2'd1) begin und_pend = 1'b1; und_a = ea[11:0]; end
        else mmem[ea[11:0]] = b;
        if (m == 3'd4) mX = mA;
        else if (m == 3'd5) mY = mA;
        else if (m == 3'd7) mX = mX + 8'd1;
      end else begin
        case (f)
          3'd0: r = b;
          3'd1: r = mA & b;
          3'd2: r = mA | b;
          3'd3: r = mA ^ b;
          3'd4: r = mA + b;
          default: r = mA - b;
        endcase
        case (m)
          3'd4: mX = r;
          3'd5: mY = r;
          3'd6: mO = r;
          3'd7: begin mO = r; mX = mX + 8'd1; end
          default: mA = r;
        endcase
      end
    end
  endtask

  task automatic compare_all(input int rq);
    int bad;
    chk(rq, "A",   {8'h00, acc},      {8'h00, mA});
    chk(rq, "X",   {8'h00, xreg},     {8'h00, mX});
    chk(rq, "Y",   {8'h00, yreg},     {8'h00, mY});
    chk(rq, "OUT", {8'h00, out_port}, {8'h00, mO});
    chk(rq, "PC",  rom_addr, mPC);
    if (und_pend) mmem[und_a] = mem[und_a];
    bad = -1;
    for (int k = 0; k < 4096; k++) if (mem[k] !== mmem[k]) begin bad = k; break; end
    if (bad < 0) chk(rq, "RAM", 16'h0, 16'h0);
    else chk(rq, "RAM", {8'h00, mem[bad]}, {8'h00, mmem[bad]});
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R12 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4096; k++) begin mem[k] = 8'(k * 7 + 3); mmem[k] = 8'(k * 7 + 3); end
    mA = 0; mX = 0; mY = 0; mO = 0; mPC = 0; und_pend = 0; und_a = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(1, "A rst", {8'h00, acc}, 16'h0);
    chk(1, "X rst", {8'h00, xreg}, 16'h0);
    chk(1, "Y rst", {8'h00, yreg}, 16'h0);
    chk(1, "OUT rst", {8'h00, out_port}, 16'h0);
    chk(1, "PC rst", rom_addr, 16'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      rom_data = VEC[i][23:8];
      in_port  = VEC[i][7:0];
      ref_exec(VEC[i][23:8], VEC[i][7:0]);
      @(negedge clk);
      compare_all(int'(VEC[i][31:24]));
    end
    // R1: reset during operation returns all registers to zero
    rom_data = 16'h0055;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(1, "A mid rst", {8'h00, acc}, 16'h0);
    chk(1, "X mid rst", {8'h00, xreg}, 16'h0);
    chk(1, "Y mid rst", {8'h00, yreg}, 16'h0);
    chk(1, "OUT mid rst", {8'h00, out_port}, 16'h0);
    chk(1, "PC mid rst", rom_addr, 16'h0);
    finish_run();
  end
endmodule